// File: doc/BRIEF.md
# Saturating 17x17 Multiply-Accumulate Unit

This block multiplies two 16-bit operands and, in the same cycle, combines the product with a 40-bit accumulator value. Each operand is widened to 17 bits with its own signed/unsigned control. A fractional mode doubles the product. The combined value can then be rounded to a 16-bit boundary and clamped to the 32-bit range. A zero flag and an overflow flag come with the result.

The first multiplier input comes from one of three places: a 16-bit temporary register that loads from its own input, the first data operand, or the high word of the accumulator input. The second multiplier input is chosen from a coefficient, the second data operand, the accumulator high word, or an immediate value. The operation is multiply-only, multiply-add or multiply-subtract. The result is registered, and a valid strobe marks it one cycle after the request.

Top module: `mac17_unit`

## Requirements
- R1: `a_sel` picks the first operand: 00 = temporary register, 01 = `dat_x`, 10 or 11 = `acc_in[31:16]`.
- R2: `b_sel` picks the second operand: 00 = `coef`, 01 = `dat_y`, 10 = `acc_in[31:16]`, 11 = `imm`.
- R3: Each operand is widened to 17 bits. When its signed flag (`a_signed`, `b_signed`) is 1, bit 15 is copied into bit 16. When the flag is 0, bit 16 is 0. The product of the two 17-bit values is taken in two's complement.
- R4: `op` 00 and 11 give the product alone. 01 gives `acc_in` + product, and 10 gives `acc_in` − product. Both use 40-bit two's-complement arithmetic that wraps modulo 2^40.
- R5: When `frac_en` is 1, the product is shifted left by one bit before it is added or subtracted.
- R6: When `rnd_en` is 1, 0x8000 is added to the 40-bit value (wrapping) and then bits 15..0 are cleared.
- R7: `res_ovf` is 1 when the value after rounding lies outside the signed 32-bit range, that is, when bits 39..31 are not all equal. When `sat_en` is 1 and there is overflow, the result is 0x007FFFFFFF for a positive value (bit 39 = 0) and 0xFF80000000 for a negative one.
- R8: `res_zero` is 1 exactly when the registered 40-bit result is zero.
- R9: When `t_load` is 1, the temporary register takes `t_din` at the clock edge. A request issued in that same cycle uses the previous contents.
- R10: A request with `in_valid` high appears on `result`, `res_ovf` and `res_zero` with `res_valid` high one cycle later. When there is no request, `res_valid` is 0 and the outputs hold their values.
- R11: A synchronous active-low reset clears `res_valid`, `result`, the flags and the temporary register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| t_load | input | 1 | Load the temporary register |
| t_din | input | 16 | Temporary register load value |
| in_valid | input | 1 | Request a multiply-accumulate |
| a_sel | input | 2 | First operand source |
| b_sel | input | 2 | Second operand source |
| a_signed | input | 1 | First operand signed |
| b_signed | input | 1 | Second operand signed |
| op | input | 2 | Multiply-only, add or subtract |
| frac_en | input | 1 | Double the product |
| rnd_en | input | 1 | Round to bit 16 |
| sat_en | input | 1 | Clamp to the 32-bit range |
| dat_x | input | 16 | First data operand |
| dat_y | input | 16 | Second data operand |
| coef | input | 16 | Coefficient operand |
| imm | input | 16 | Immediate operand |
| acc_in | input | 40 | Accumulator value |
| res_valid | output | 1 | Result strobe |
| result | output | 40 | Registered result |
| res_zero | output | 1 | Result is zero |
| res_ovf | output | 1 | 32-bit overflow detected |

## Verification
The assertions assume that reset is applied at the start with `in_valid` low. They also assume that every control input is a defined 0 or 1 at each sampling edge. The range and low-bit checks rest only on the mode bits captured with a request, so they hold for any operand values. The bench holds `in_valid` low throughout reset and drives every input on the falling edge. It mixes hand-picked corner vectors with arbitrary operands, modes and load patterns, including idle gaps, so all of its stimulus stays inside those assumptions.

// File: rtl/mac17_pkg.sv
// Shared widths and encodings for the multiply-accumulate unit.
// Assumes the accumulator is at least twice the operand width.
package mac17_pkg;
    localparam int OPW_D  = 16;
    localparam int ACCW_D = 40;
    localparam int SATW_D = 32;
    localparam int RNDW_D = 16;

    typedef enum logic [1:0] {
        OP_MPY = 2'b00,
        OP_MAC = 2'b01,
        OP_MSU = 2'b10,
        OP_ALT = 2'b11
    } mac_op_e;

    typedef enum logic [1:0] {
        BSRC_COEF = 2'b00,
        BSRC_DATA = 2'b01,
        BSRC_ACC  = 2'b10,
        BSRC_IMM  = 2'b11
    } bsrc_e;
endpackage

// File: rtl/mac17_opsel.sv
// Operand source selection for both multiplier inputs.
// Assumes the selects are stable during the request cycle.
module mac17_opsel
    import mac17_pkg::*;
#(
    parameter int OPW = OPW_D
) (
    input  logic [1:0]     a_sel,
    input  logic [1:0]     b_sel,
    input  logic [OPW-1:0] t_q,
    input  logic [OPW-1:0] dat_x,
    input  logic [OPW-1:0] dat_y,
    input  logic [OPW-1:0] coef,
    input  logic [OPW-1:0] imm,
    input  logic [OPW-1:0] acc_hi,
    output logic [OPW-1:0] a_raw,
    output logic [OPW-1:0] b_raw
);
    // First operand: temp, data, or accumulator high word.
    always_comb begin
        if (a_sel[1])      a_raw = acc_hi;
        else if (a_sel[0]) a_raw = dat_x;
        else               a_raw = t_q;
    end

    // Second operand: coefficient, data, accumulator high word, immediate.
    always_comb begin
        case (bsrc_e'(b_sel))
            BSRC_COEF: b_raw = coef;
            BSRC_DATA: b_raw = dat_y;
            BSRC_ACC:  b_raw = acc_hi;
            default:   b_raw = imm;
        endcase
    end
endmodule

// File: rtl/mac17_ext.sv
// Widens one operand by a bit, copying the sign or inserting zero.
module mac17_ext #(
    parameter int OPW = 16
) (
    input  logic               is_signed,
    input  logic [OPW-1:0]     raw,
    output logic signed [OPW:0] ext
);
    assign ext = {is_signed & raw[OPW-1], raw};
endmodule

// File: rtl/mac17_core.sv
// Signed multiply, optional doubling, and add/subtract into the accumulator.
// Assumes ACCW is at least the product width plus one.
module mac17_core
    import mac17_pkg::*;
#(
    parameter int MULW = OPW_D + 1,
    parameter int ACCW = ACCW_D
) (
    input  logic signed [MULW-1:0] a_ext,
    input  logic signed [MULW-1:0] b_ext,
    input  logic                   frac_en,
    input  logic [1:0]             op,
    input  logic [ACCW-1:0]        acc_in,
    output logic [ACCW-1:0]        sum
);
    localparam int PW = 2 * MULW;

    logic signed [PW-1:0] prod;
    logic [ACCW-1:0]      prod_ext;
    logic [ACCW-1:0]      prod_fin;

    assign prod     = a_ext * b_ext;
    assign prod_ext = {{(ACCW-PW){prod[PW-1]}}, prod};
    assign prod_fin = frac_en ? (prod_ext << 1) : prod_ext;

    // Combine the product with the accumulator per the operation code.
    always_comb begin
        case (mac_op_e'(op))
            OP_MAC:  sum = acc_in + prod_fin;
            OP_MSU:  sum = acc_in - prod_fin;
            default: sum = prod_fin;
        endcase
    end
endmodule

// File: rtl/mac17_post.sv
// Rounding, 32-bit overflow detection, saturation and zero detection.
module mac17_post
    import mac17_pkg::*;
#(
    parameter int ACCW = ACCW_D,
    parameter int SATW = SATW_D,
    parameter int RNDW = RNDW_D
) (
    input  logic [ACCW-1:0] sum,
    input  logic            rnd_en,
    input  logic            sat_en,
    output logic [ACCW-1:0] res,
    output logic            ovf,
    output logic            zero
);
    localparam int              GW       = ACCW - SATW + 1;
    localparam logic [ACCW-1:0] RND_ADD  = ACCW'(1) << (RNDW - 1);
    localparam logic [ACCW-1:0] RND_MASK = ~((ACCW'(1) << RNDW) - ACCW'(1));
    localparam logic [ACCW-1:0] SAT_MAX  = {{GW{1'b0}}, {(SATW-1){1'b1}}};
    localparam logic [ACCW-1:0] SAT_MIN  = {{GW{1'b1}}, {(SATW-1){1'b0}}};

    logic [ACCW-1:0] rounded;
    logic [GW-1:0]   guard;

    assign rounded = rnd_en ? ((sum + RND_ADD) & RND_MASK) : sum;
    assign guard   = rounded[ACCW-1:SATW-1];
    assign ovf     = !((&guard) || !(|guard));

    // Clamp by sign when saturation is on and the value left 32 bits.
    always_comb begin
        if (sat_en && ovf) res = rounded[ACCW-1] ? SAT_MIN : SAT_MAX;
        else               res = rounded;
    end

    assign zero = (res == '0);
endmodule

// File: rtl/mac17_unit.sv
// Single-cycle 17x17 multiply-accumulate with temp register and a
// registered result. Assumes ACCW >= 2*OPW + 3 and SATW > RNDW.
module mac17_unit
    import mac17_pkg::*;
#(
    parameter int OPW  = OPW_D,
    parameter int ACCW = ACCW_D,
    parameter int SATW = SATW_D,
    parameter int RNDW = RNDW_D
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            t_load,
    input  logic [OPW-1:0]  t_din,
    input  logic            in_valid,
    input  logic [1:0]      a_sel,
    input  logic [1:0]      b_sel,
    input  logic            a_signed,
    input  logic            b_signed,
    input  logic [1:0]      op,
    input  logic            frac_en,
    input  logic            rnd_en,
    input  logic            sat_en,
    input  logic [OPW-1:0]  dat_x,
    input  logic [OPW-1:0]  dat_y,
    input  logic [OPW-1:0]  coef,
    input  logic [OPW-1:0]  imm,
    input  logic [ACCW-1:0] acc_in,
    output logic            res_valid,
    output logic [ACCW-1:0] result,
    output logic            res_zero,
    output logic            res_ovf
);
    localparam int MULW = OPW + 1;
    localparam int NOPS = 2;

    logic [OPW-1:0]         t_q;
    logic [OPW-1:0]         raw   [NOPS];
    logic                   sgn   [NOPS];
    logic signed [MULW-1:0] ext   [NOPS];
    logic [ACCW-1:0]        sum;
    logic [ACCW-1:0]        res_d;
    logic                   ovf_d;
    logic                   zero_d;

    // Temporary operand register.
    always_ff @(posedge clk) begin
        if (!rst_n)      t_q <= '0;
        else if (t_load) t_q <= t_din;
    end

    mac17_opsel #(.OPW(OPW)) u_opsel (
        .a_sel  (a_sel),
        .b_sel  (b_sel),
        .t_q    (t_q),
        .dat_x  (dat_x),
        .dat_y  (dat_y),
        .coef   (coef),
        .imm    (imm),
        .acc_hi (acc_in[2*OPW-1:OPW]),
        .a_raw  (raw[0]),
        .b_raw  (raw[1])
    );

    assign sgn[0] = a_signed;
    assign sgn[1] = b_signed;

    for (genvar i = 0; i < NOPS; i++) begin : g_ext
        mac17_ext #(.OPW(OPW)) u_ext (
            .is_signed (sgn[i]),
            .raw       (raw[i]),
            .ext       (ext[i])
        );
    end

    mac17_core #(.MULW(MULW), .ACCW(ACCW)) u_core (
        .a_ext   (ext[0]),
        .b_ext   (ext[1]),
        .frac_en (frac_en),
        .op      (op),
        .acc_in  (acc_in),
        .sum     (sum)
    );

    mac17_post #(.ACCW(ACCW), .SATW(SATW), .RNDW(RNDW)) u_post (
        .sum    (sum),
        .rnd_en (rnd_en),
        .sat_en (sat_en),
        .res    (res_d),
        .ovf    (ovf_d),
        .zero   (zero_d)
    );

    // Output register: capture on request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            result    <= '0;
            res_zero  <= 1'b0;
            res_ovf   <= 1'b0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) begin
                result   <= res_d;
                res_zero <= zero_d;
                res_ovf  <= ovf_d;
            end
        end
    end
endmodule

// File: rtl/mac17_chk.sv
// Property checker for mac17_unit, attached through bind.
module mac17_chk #(
    parameter int OPW  = 16,
    parameter int ACCW = 40,
    parameter int SATW = 32,
    parameter int RNDW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            t_load,
    input logic [OPW-1:0]  t_din,
    input logic [OPW-1:0]  t_q,
    input logic            rnd_en,
    input logic            sat_en,
    input logic            res_valid,
    input logic [ACCW-1:0] result,
    input logic            res_zero,
    input logic            res_ovf
);
    localparam int              GW      = ACCW - SATW + 1;
    localparam logic [ACCW-1:0] SAT_MAX = {{GW{1'b0}}, {(SATW-1){1'b1}}};
    localparam logic [ACCW-1:0] SAT_MIN = {{GW{1'b1}}, {(SATW-1){1'b0}}};

    a_r10_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(res_zero) && $stable(res_ovf)));
    a_r9_t_load: assert property (@(posedge clk) disable iff (!rst_n)
        t_load |=> (t_q == $past(t_din)));
    a_r9_t_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !t_load |=> $stable(t_q));
    a_r7_sat_range: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sat_en) |=>
            ((&result[ACCW-1:SATW-1]) || !(|result[ACCW-1:SATW-1])));
    a_r7_sat_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sat_en) |=>
            (!res_ovf || result == SAT_MAX || result == SAT_MIN));
    a_r6_round_low: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rnd_en && !sat_en) |=> (result[RNDW-1:0] == '0));
    a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_zero == (result == '0)));
    a_r11_reset: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && result == '0 && t_q == '0));
endmodule

bind mac17_unit mac17_chk #(.OPW(OPW), .ACCW(ACCW), .SATW(SATW), .RNDW(RNDW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .t_load    (t_load),
    .t_din     (t_din),
    .t_q       (t_q),
    .rnd_en    (rnd_en),
    .sat_en    (sat_en),
    .res_valid (res_valid),
    .result    (result),
    .res_zero  (res_zero),
    .res_ovf   (res_ovf)
);

// File: tb/sim_mac17_unit.sv
// Scoreboard bench: drive task queues expectations, monitor compares.
module sim_mac17_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        t_load = 1'b0;
    logic [15:0] t_din = '0;
    logic        in_valid = 1'b0;
    logic [1:0]  a_sel = '0, b_sel = '0, op = '0;
    logic        a_signed = 1'b0, b_signed = 1'b0;
    logic        frac_en = 1'b0, rnd_en = 1'b0, sat_en = 1'b0;
    logic [15:0] dat_x = '0, dat_y = '0, coef = '0, imm = '0;
    logic [39:0] acc_in = '0;
    logic        res_valid, res_zero, res_ovf;
    logic [39:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] tb_t = '0;
    logic [39:0] last_res = '0;

    typedef struct {
        string       tag;
        logic [39:0] res;
        logic        ovf;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    mac17_unit u0 (.*);

    task automatic chk(bit ok, string tag, logic [39:0] act, logic [39:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference from the requirements: returns {ovf, result}.
    function automatic logic [40:0] model(logic [15:0] a, logic [15:0] b,
            logic sa, logic sb_, logic [1:0] o, logic fr, logic rn, logic st,
            logic [39:0] acc);
        longint av, bv, p, s, accs;
        logic [39:0] w;
        logic ov;
        av = sa  ? longint'($signed(a)) : longint'(a);
        bv = sb_ ? longint'($signed(b)) : longint'(b);
        p = av * bv;
        if (fr) p = p * 2;
        accs = longint'($signed(acc));
        case (o)
            2'b01:   s = accs + p;
            2'b10:   s = accs - p;
            default: s = p;
        endcase
        w = s[39:0];
        s = longint'($signed(w));
        if (rn) begin
            s = s + 32768;
            w = s[39:0];
            s = longint'($signed(w));
            s = s & ~longint'(65535);
        end
        ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        if (st && ov) s = (s < 0) ? -64'sd2147483648 : 64'sd2147483647;
        return {ov, s[39:0]};
    endfunction

    task automatic drive(string tag, logic tld, logic [15:0] tv,
            logic [1:0] asl, logic [1:0] bsl, logic sa, logic sb_,
            logic [1:0] o, logic fr, logic rn, logic st,
            logic [15:0] x, logic [15:0] y, logic [15:0] cf, logic [15:0] im,
            logic [39:0] acc, logic use_exp, logic [39:0] eres, logic eovf);
        logic [15:0] a, b;
        logic [40:0] m;
        exp_t e;
        @(negedge clk);
        t_load = tld; t_din = tv; a_sel = asl; b_sel = bsl;
        a_signed = sa; b_signed = sb_; op = o;
        frac_en = fr; rnd_en = rn; sat_en = st;
        dat_x = x; dat_y = y; coef = cf; imm = im; acc_in = acc;
        in_valid = 1'b1;
        a = (asl == 2'b00) ? tb_t : (asl == 2'b01) ? x : acc[31:16];
        case (bsl)
            2'b00:   b = cf;
            2'b01:   b = y;
            2'b10:   b = acc[31:16];
            default: b = im;
        endcase
        m = model(a, b, sa, sb_, o, fr, rn, st, acc);
        e.tag = tag;
        e.res = use_exp ? eres : m[39:0];
        e.ovf = use_exp ? eovf : m[40];
        sb.push_back(e);
        if (tld) tb_t = tv;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            t_load = 1'b0;
            dat_x = dat_x + 16'h1111;
            acc_in = ~acc_in;
        end
    endtask

    // Monitor: compares each strobed result with the next queued item.
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            if (res_valid) begin
                if (sb.size() == 0) begin
                    chk(0, "R10 unexpected strobe", {39'b0, res_valid}, 40'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(result == e.res, e.tag, result, e.res);
                    chk(res_ovf == e.ovf, {e.tag, " R7 ovf"}, {39'b0, res_ovf}, {39'b0, e.ovf});
                    chk(res_zero == (e.res == '0), {e.tag, " R8 zero"},
                        {39'b0, res_zero}, {39'b0, (e.res == '0)});
                end
                last_res = result;
            end else begin
                chk(result == last_res, "R10 hold", result, last_res);
            end
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", sb.size(), 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(res_valid == 1'b0, "R11 reset valid", {39'b0, res_valid}, 40'd0);
        chk(result == 40'd0, "R11 reset result", result, 40'd0);
        // R9: same-cycle load uses old temp (0); next request sees 3.
        drive("R9 old temp", 1, 16'd3, 2'b00, 2'b00, 1, 1, 2'b00, 0, 0, 0,
              0, 0, 16'd5, 0, 0, 1, 40'd0, 0);
        drive("R9 R1 new temp", 0, 0, 2'b00, 2'b00, 1, 1, 2'b00, 0, 0, 0,
              0, 0, 16'd5, 0, 0, 1, 40'd15, 0);
        drive("R3 signed", 0, 0, 2'b01, 2'b01, 1, 1, 2'b00, 0, 0, 0,
              16'hFFFE, 16'd7, 0, 0, 0, 1, 40'hFFFFFFFFF2, 0);
        drive("R3 R2 unsigned imm", 0, 0, 2'b01, 2'b11, 0, 1, 2'b00, 0, 0, 0,
              16'hFFFE, 0, 0, 16'd2, 0, 1, 40'h000001FFFC, 0);
        drive("R1 R2 acc high", 0, 0, 2'b10, 2'b10, 1, 1, 2'b00, 0, 0, 0,
              0, 0, 0, 0, 40'h0000030000, 1, 40'd9, 0);
        drive("R4 add", 0, 0, 2'b01, 2'b01, 1, 1, 2'b01, 0, 0, 0,
              16'd4, 16'd5, 0, 0, 40'd100, 1, 40'd120, 0);
        drive("R4 sub", 0, 0, 2'b01, 2'b01, 1, 1, 2'b10, 0, 0, 0,
              16'd4, 16'd5, 0, 0, 40'd100, 1, 40'd80, 0);
        drive("R4 sub negative", 0, 0, 2'b01, 2'b01, 1, 1, 2'b10, 0, 0, 0,
              16'd4, 16'd5, 0, 0, 40'd10, 1, 40'hFFFFFFFFF6, 0);
        drive("R5 R7 frac sat", 0, 0, 2'b01, 2'b01, 1, 1, 2'b00, 1, 0, 1,
              16'h8000, 16'h8000, 0, 0, 0, 1, 40'h007FFFFFFF, 1);
        drive("R5 frac nosat", 0, 0, 2'b01, 2'b01, 1, 1, 2'b00, 1, 0, 0,
              16'h8000, 16'h8000, 0, 0, 0, 1, 40'h0080000000, 1);
        drive("R5 frac small", 0, 0, 2'b01, 2'b01, 1, 1, 2'b00, 1, 0, 0,
              16'd3, 16'd5, 0, 0, 0, 1, 40'd30, 0);
        drive("R6 round up", 0, 0, 2'b01, 2'b01, 0, 0, 2'b00, 0, 1, 0,
              16'd3, 16'h8000, 0, 0, 0, 1, 40'h0000020000, 0);
        drive("R6 round down", 0, 0, 2'b01, 2'b01, 1, 1, 2'b01, 0, 1, 0,
              0, 0, 0, 0, 40'h0000017FFF, 1, 40'h0000010000, 0);
        drive("R7 neg clamp", 0, 0, 2'b01, 2'b01, 1, 1, 2'b10, 0, 0, 1,
              16'd1, 16'd1, 0, 0, 40'hFF80000000, 1, 40'hFF80000000, 1);
        drive("R7 neg noclamp", 0, 0, 2'b01, 2'b01, 1, 1, 2'b10, 0, 0, 0,
              16'd1, 16'd1, 0, 0, 40'hFF80000000, 1, 40'hFF7FFFFFFF, 1);
        drive("R4 wrap", 0, 0, 2'b01, 2'b01, 1, 1, 2'b01, 0, 0, 0,
              16'd1, 16'd1, 0, 0, 40'h7FFFFFFFFF, 1, 40'h8000000000, 1);
        drive("R4 op11 product", 0, 0, 2'b01, 2'b01, 1, 1, 2'b11, 0, 0, 0,
              16'd6, 16'd7, 0, 0, 40'd1000, 1, 40'd42, 0);
        drive("R1 sel11 acc high", 0, 0, 2'b11, 2'b11, 1, 1, 2'b00, 0, 0, 0,
              16'd9, 0, 0, 16'd2, 40'h0000050000, 1, 40'd10, 0);
        idle(5);
        for (int i = 0; i < 400; i++) begin
            drive("R4 random", 1'($urandom), 16'($urandom), 2'($urandom),
                  2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom),
                  16'($urandom), 16'($urandom), 16'($urandom),
                  {8'($urandom), 32'($urandom)}, 0, 40'd0, 0);
            if (($urandom % 5) == 0) idle(1 + ($urandom % 3));
        end
        idle(4);
        chk(sb.size() == 0, "R10 all results seen", 40'(sb.size()), 40'd0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule